// File: doc/BRIEF.md
# Look-Ahead Input Port for a Three-Dimensional Mesh Router

This block is a single input port of a seven-way router in a 3D mesh. Its neighbours are the four planar directions, above, below and the local processing tile. Flits from the upstream router enter a small buffer. Upstream flow control is stall/go: `in_go` high means the port can take a flit this cycle. The flit at the front of the buffer is presented to the switch allocator.

Routing is look-ahead. A header flit already carries the output port this router must use, because the upstream router chose it. The port turns that field into a held one-hot switch request. It also works out which port the *next* router will need, using dimension order X, then Y, then Z. That result is written into the outgoing header. Each packet holds its request from the header until the tail flit leaves. A packet that fits in the buffer moves as cut-through, and a longer one moves as wormhole.

Back-pressure rules: a flit is taken on an edge where `in_valid` and `in_go` are both high. A flit leaves on an edge where `grant` and `out_valid` are both high. `grant` at any other time has no effect.

Top module: `mesh3d_inport`

## Requirements
- R1: `in_go` is high exactly when the buffer holds fewer than DEPTH flits. A flit offered while `in_go` is low is not stored.
- R2: Flits leave in arrival order, with the payload (bits PW-1:0) unchanged.
- R3: After reset, `in_go` is 1 and `sw_req`, `port_req` and `out_valid` are 0.
- R4: Port codes are 0 local, 1 north (+y), 2 east (+x), 3 south (-y), 4 west (-x), 5 up (+z), 6 down (-z). Flit bits, MSB first, are: head, tail, a 3-bit port code, dest x, dest y, dest z (CW bits each), then the payload. When an idle port sees a header at the buffer front, `port_req` shows only the bit for the header's port code from the next cycle on.
- R5: `sw_req` and `port_req` stay unchanged until the tail flit has been granted, and clear on the following cycle.
- R6: `out_valid` is high exactly while a request is held and the buffer is not empty. `grant` without `out_valid` moves nothing.
- R7: In the header as it leaves, the port field is the port the neighbour in the current direction will use. That neighbour picks east or west while its x differs from the destination, then north or south on y, then up or down on z.
- R8: The outgoing port field is local when the neighbour's coordinates equal the destination, and also when the incoming port field is itself local.
- R9: Body and tail flits that are not headers leave bit for bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream flit present |
| in_flit | input | PW+3*CW+5 | Upstream flit |
| in_go | output | 1 | Stall/go to upstream: 1 means a flit can be taken |
| sw_req | output | 1 | Switch request to the allocator |
| port_req | output | 7 | One-hot output port requested |
| grant | input | 1 | Allocator grant, takes the front flit |
| out_valid | output | 1 | Front flit is offered to the crossbar |
| out_flit | output | PW+3*CW+5 | Front flit, header port field rewritten |

## Verification
Three kinds of internal fault show up at the ports. A wrong buffer count shows in `in_go` on the cycle it appears, and later as a lost or duplicated flit in `out_flit`. A wrong held route shows in `port_req` one cycle after the header reaches the front. A request released early drops `sw_req` while body flits are still queued. Faults in the look-ahead logic show only in headers, so headers aimed along every direction and at the local port are used. Stalled grants and an overfilled buffer expose faults in ordering and in the full condition.

// File: rtl/mesh3d_pkg.sv
package mesh3d_pkg;
  localparam int NPORTS = 7;
  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_NORTH = 3'd1,
    P_EAST  = 3'd2,
    P_SOUTH = 3'd3,
    P_WEST  = 3'd4,
    P_UP    = 3'd5,
    P_DOWN  = 3'd6
  } port_e;
endpackage

// File: rtl/mesh3d_fifo.sv
module mesh3d_fifo #(
  parameter int W = 19,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wr_data,
  input  logic         pop,
  output logic         can_take,
  output logic         not_empty,
  output logic [W-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic            do_wr, do_rd;

  assign can_take  = (count < CNTW'(DEPTH));
  assign not_empty = (count != '0);
  assign rd_data   = mem[rd_ptr];
  assign do_wr     = push && can_take;
  assign do_rd     = pop && not_empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && can_take && !pop) |=> (count == $past(count) + 1'b1)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!can_take && !pop) |=> !can_take); // R1
  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (not_empty && !pop) |=> $stable(rd_data)); // R2
endmodule

// File: rtl/mesh3d_lookahead.sv
module mesh3d_lookahead
  import mesh3d_pkg::*;
#(
  parameter int CW = 2,
  parameter int MY_X = 1,
  parameter int MY_Y = 1,
  parameter int MY_Z = 1
) (
  input  logic [2:0]    cur_port,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [CW-1:0] dst_z,
  output logic [2:0]    next_port
);
  logic [CW:0] nx, ny, nz, tx, ty, tz;
  port_e       pick;

  assign tx = {1'b0, dst_x};
  assign ty = {1'b0, dst_y};
  assign tz = {1'b0, dst_z};

  always_comb begin
    nx = (CW+1)'(MY_X);
    ny = (CW+1)'(MY_Y);
    nz = (CW+1)'(MY_Z);
    case (cur_port)
      P_EAST:  nx = nx + 1'b1;
      P_WEST:  nx = nx - 1'b1;
      P_NORTH: ny = ny + 1'b1;
      P_SOUTH: ny = ny - 1'b1;
      P_UP:    nz = nz + 1'b1;
      P_DOWN:  nz = nz - 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    if (cur_port == P_LOCAL) pick = P_LOCAL;
    else if (tx > nx)        pick = P_EAST;
    else if (tx < nx)        pick = P_WEST;
    else if (ty > ny)        pick = P_NORTH;
    else if (ty < ny)        pick = P_SOUTH;
    else if (tz > nz)        pick = P_UP;
    else if (tz < nz)        pick = P_DOWN;
    else                     pick = P_LOCAL;
  end

  assign next_port = pick;
endmodule

// File: rtl/mesh3d_reqctl.sv
module mesh3d_reqctl
  import mesh3d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              front_valid,
  input  logic              front_head,
  input  logic              front_tail,
  input  logic [2:0]        front_port,
  input  logic              grant,
  output logic              sw_req,
  output logic [NPORTS-1:0] port_req,
  output logic              out_valid,
  output logic              pop
);
  logic       active;
  logic [2:0] route;
  logic       tail_leaves;

  assign out_valid   = active && front_valid;
  assign pop         = grant && out_valid;
  assign tail_leaves = pop && front_tail;
  assign sw_req      = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      route  <= P_LOCAL;
    end else if (active) begin
      if (tail_leaves) active <= 1'b0;
    end else if (front_valid && front_head) begin
      active <= 1'b1;
      route  <= front_port;
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_req
    assign port_req[g] = active && (route == 3'(g));
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> ($countones(port_req) == 1)); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !tail_leaves) |=> (sw_req && $stable(port_req))); // R5
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tail_leaves |=> !sw_req); // R5
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_req |-> (port_req == '0 && !out_valid)); // R6
endmodule

// File: rtl/mesh3d_inport.sv
module mesh3d_inport
  import mesh3d_pkg::*;
#(
  parameter int CW = 2,
  parameter int PW = 8,
  parameter int DEPTH = 4,
  parameter int MY_X = 1,
  parameter int MY_Y = 1,
  parameter int MY_Z = 1,
  localparam int FW = PW + 3*CW + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FW-1:0]     in_flit,
  output logic              in_go,
  output logic              sw_req,
  output logic [NPORTS-1:0] port_req,
  input  logic              grant,
  output logic              out_valid,
  output logic [FW-1:0]     out_flit
);
  localparam int Z_LO  = PW;
  localparam int Y_LO  = PW + CW;
  localparam int X_LO  = PW + 2*CW;
  localparam int NP_LO = PW + 3*CW;
  localparam int TAIL  = FW - 2;
  localparam int HEAD  = FW - 1;

  logic [FW-1:0] front;
  logic          front_valid, pop;
  logic [2:0]    next_port;

  mesh3d_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid), .wr_data(in_flit),
    .pop(pop),
    .can_take(in_go), .not_empty(front_valid), .rd_data(front)
  );

  mesh3d_lookahead #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y), .MY_Z(MY_Z)) u_look (
    .cur_port(front[NP_LO +: 3]),
    .dst_x(front[X_LO +: CW]), .dst_y(front[Y_LO +: CW]), .dst_z(front[Z_LO +: CW]),
    .next_port(next_port)
  );

  mesh3d_reqctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .front_valid(front_valid), .front_head(front[HEAD]), .front_tail(front[TAIL]),
    .front_port(front[NP_LO +: 3]), .grant(grant),
    .sw_req(sw_req), .port_req(port_req), .out_valid(out_valid), .pop(pop)
  );

  always_comb begin
    out_flit = front;
    if (front[HEAD]) out_flit[NP_LO +: 3] = next_port;
  end

  AST_LOCAL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && front[HEAD] && front[NP_LO +: 3] == P_LOCAL)
      |-> (out_flit[NP_LO +: 3] == P_LOCAL)); // R8
  AST_BODY_INTACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_flit[HEAD]) |-> (out_flit[PW-1:0] == front[PW-1:0])); // R9
endmodule

// File: tb/test_mesh3d_inport.sv
`timescale 1ns/1ps
module test_mesh3d_inport;
  localparam int CW = 2, PW = 8, DEPTH = 4;
  localparam int FW = PW + 3*CW + 5;
  localparam int NPL = PW + 3*CW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, in_valid, in_go, sw_req, grant, out_valid;
  logic [FW-1:0] in_flit, out_flit;
  logic [6:0]    port_req;

  mesh3d_inport i_mesh3d_inport (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit), .in_go(in_go),
    .sw_req(sw_req), .port_req(port_req), .grant(grant),
    .out_valid(out_valid), .out_flit(out_flit)
  );

  int total = 0, bad = 0, cyc = 0, gmode = 0, m_route = 0;
  bit checking = 0, spam = 0, drv_junk = 0, m_act = 0;
  logic [FW-1:0] stim[$];
  logic [FW-1:0] mq[$];

  function automatic logic [FW-1:0] mk(bit h, bit t, int np, int x, int y, int z, int pl);
    return {h, t, 3'(np), CW'(x), CW'(y), CW'(z), PW'(pl)};
  endfunction

  function automatic int ref_next(int cur, int x, int y, int z);
    int nx = 1, ny = 1, nz = 1;
    if (cur == 0) return 0;
    case (cur)
      1: ny++; 2: nx++; 3: ny--; 4: nx--; 5: nz++; 6: nz--;
      default: ;
    endcase
    if (x > nx) return 2;
    if (x < nx) return 4;
    if (y > ny) return 1;
    if (y < ny) return 3;
    if (z > nz) return 5;
    if (z < nz) return 6;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic packet(int np, int x, int y, int z, int nbody, int base);
    stim.push_back(mk(1, nbody == 0, np, x, y, z, base));
    for (int i = 1; i <= nbody; i++)
      stim.push_back(mk(0, i == nbody, 0, 0, 0, 0, base + i));
  endtask

  task automatic settle();
    while (stim.size() != 0 || mq.size() != 0 || m_act) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // behavioural model of the port, advanced on each edge
  always @(posedge clk) begin
    bit pop, push;
    logic [FW-1:0] f;
    if (!rst_n) begin
      mq.delete();
      m_act = 0;
    end else begin
      push = in_valid && (mq.size() < DEPTH);
      pop  = grant && m_act && (mq.size() > 0);
      if (pop) begin
        f = mq.pop_front();
        if (f[FW-2]) m_act = 0;
      end else if (!m_act && mq.size() > 0 && mq[0][FW-1]) begin
        m_act = 1;
        m_route = int'(mq[0][NPL +: 3]);
      end
      if (push) begin
        mq.push_back(in_flit);
        if (!drv_junk) void'(stim.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    logic [FW-1:0] e;
    int rn;
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (checking) begin
      chk("R1 in_go", 32'(in_go), 32'(mq.size() < DEPTH));
      chk("R5 sw_req", 32'(sw_req), 32'(m_act));
      chk("R4 port_req", 32'(port_req), m_act ? (32'd1 << m_route) : 32'd0);
      chk("R6 out_valid", 32'(out_valid), 32'(m_act && mq.size() > 0));
      if (m_act && mq.size() > 0) begin
        e = mq[0];
        chk("R2 payload order", 32'(out_flit[PW-1:0]), 32'(e[PW-1:0]));
        if (e[FW-1]) begin
          rn = ref_next(int'(e[NPL +: 3]), int'(e[PW+2*CW +: CW]),
                        int'(e[PW+CW +: CW]), int'(e[PW +: CW]));
          e[NPL +: 3] = 3'(rn);
          if (rn == 0) chk("R8 local next port", 32'(out_flit), 32'(e));
          else         chk("R7 look-ahead header", 32'(out_flit), 32'(e));
        end else begin
          chk("R9 body flit", 32'(out_flit), 32'(e));
        end
      end
    end
    case (gmode)
      0: grant = 1'b1;
      1: grant = 1'b0;
      default: grant = (cyc % 3) != 0;
    endcase
    drv_junk = 0;
    in_valid = 1'b0;
    in_flit  = '0;
    if (spam && !in_go) begin
      in_valid = 1'b1;
      in_flit  = mk(1, 1, 6, 3, 3, 3, 8'hEE);
      drv_junk = 1;
    end else if (stim.size() != 0) begin
      in_valid = 1'b1;
      in_flit  = stim[0];
    end
  end

  initial begin
    rst_n = 1'b0; grant = 1'b0; in_valid = 1'b0; in_flit = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R3 in_go", 32'(in_go), 32'd1);
    chk("R3 sw_req", 32'(sw_req), 32'd0);
    chk("R3 port_req", 32'(port_req), 32'd0);
    chk("R3 out_valid", 32'(out_valid), 32'd0);
    checking = 1;
    // R7 each direction, grant always on
    packet(2, 3, 1, 1, 2, 8'h10);
    packet(1, 1, 3, 0, 1, 8'h20);
    packet(4, 0, 0, 0, 0, 8'h30);
    packet(5, 1, 1, 3, 3, 8'h40);
    packet(3, 2, 0, 0, 1, 8'h50);
    packet(2, 0, 2, 2, 1, 8'h60);
    packet(5, 1, 1, 0, 0, 8'h70);
    settle();
    // R8 match at neighbour, and local pass-through
    packet(6, 1, 1, 0, 2, 8'h80);
    packet(0, 3, 3, 3, 1, 8'h90);
    settle();
    // R1 fill with stalled grant and junk offered while full, R5 hold
    gmode = 1; spam = 1;
    packet(1, 2, 2, 2, 5, 8'hA0);
    repeat (20) @(negedge clk);
    spam = 0; gmode = 2;
    settle();
    // R6 irregular grants, back-to-back packets of mixed length
    packet(3, 1, 0, 3, 0, 8'hB0);
    packet(6, 0, 1, 0, 4, 8'hC0);
    packet(1, 1, 2, 1, 0, 8'hD0);
    packet(4, 0, 1, 1, 2, 8'hE0);
    settle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule